// File: doc/BRIEF.md
# SOF-Referenced Audio Clock Meter

This block counts how many local audio clock ticks pass between consecutive USB start-of-frame events, so that firmware can compute rate feedback for an asynchronous isochronous audio stream. Start-of-frame events nominally come every 125 µs in high-speed operation and every 1 ms in full-speed operation.

Each USB port supplies a one-cycle start-of-frame strobe in the system clock domain. The block widens each strobe into a pulse of fixed length and passes it through a synchronizer into the audio master clock domain. There, one free-running counter serves as the timebase for all channels. On the rising edge of a synchronized pulse, the channel stamps the counter value and reports the modular difference from its previous stamp. Because all channels share one counter, their measurements can be compared directly.

A channel's results are a delta word, a valid flag that firmware acknowledges, and a sticky overrun flag. A per-channel enable discards strobes and clears the channel's history.

Top module: `sof_audio_meter`

## Requirements
- R1: After reset, every `tick_delta` word is 0, and all `delta_valid` and `delta_ovr` bits are 0.
- R2: A strobe accepted on `sof_stb[i]` produces an internal pulse that stays high for exactly `STRETCH` system clock cycles. A strobe that arrives while that pulse is high is ignored, so one pulse yields exactly one capture.
- R3: The timebase is a `CNT_W`-bit counter that increments on every `aud_clk` cycle and wraps. The reported delta is (new stamp − previous stamp) mod 2^`CNT_W`, and it is correct across a counter wrap.
- R4: The first capture after reset, or after a channel is re-enabled, only records the stamp. `delta_valid` stays 0 and `tick_delta` is unchanged.
- R5: All channels are stamped from the same counter. Strobes issued to two channels in the same cycles give identical deltas.
- R6: Each new delta sets `delta_valid[i]`. A high `rd_ack[i]`, sampled on `aud_clk`, clears it.
- R7: If a new delta arrives while `delta_valid[i]` is still 1 and no acknowledge is present, `delta_ovr[i]` is set. The newest delta replaces the old one. The overrun bit stays set through acknowledges until the channel is disabled or reset.
- R8: While `chan_en[i]` is 0, strobes on channel i are ignored: `tick_delta` holds its value, `delta_valid[i]` and `delta_ovr[i]` are 0, and the stored history is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock, strobe domain |
| sys_rst | input | 1 | Synchronous active-high reset, system domain |
| sof_stb | input | NCH | One-cycle start-of-frame strobe per channel |
| aud_clk | input | 1 | Audio master clock, timebase and result domain |
| aud_rst | input | 1 | Synchronous active-high reset, audio domain |
| chan_en | input | NCH | Per-channel enable (audio domain) |
| rd_ack | input | NCH | Per-channel acknowledge that clears the valid flag |
| tick_delta | output | NCH*CNT_W | Packed per-channel tick deltas, channel i at bits [i*CNT_W +: CNT_W] |
| delta_valid | output | NCH | New delta available |
| delta_ovr | output | NCH | Sticky: a delta was overwritten before it was acknowledged |

## Verification
The bench builds the block with two channels, a 12-bit timebase and a 16-cycle stretch. With a 12-bit counter, the counter wraps many times during the run, and a directed gap of 4080 ticks lands just below the wrap limit. The shorter stretch keeps each frame gap short while still lasting longer than two audio clock periods. The system clock runs at 8 ns and the audio clock at 20 ns. Frame gaps are therefore multiples of 40 ns, which fixes the clock phase, so each expected delta is exactly two ticks per five system cycles, reduced modulo 4096.

// File: rtl/sofm_pkg.sv
package sofm_pkg;
  // Bits needed to hold the value n.
  function automatic int unsigned cnt_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/sofm_stretch.sv
// Widens a one-cycle strobe to exactly WIDTH cycles; ignores retriggers.
module sofm_stretch #(
  parameter int unsigned WIDTH = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic stb,
  output logic pulse
);
  localparam int unsigned CW = sofm_pkg::cnt_bits(WIDTH);

  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      left  <= '0;
      pulse <= 1'b0;
    end else if (left == '0) begin
      if (stb) begin
        left  <= CW'(WIDTH);
        pulse <= 1'b1;
      end
    end else begin
      left  <= left - 1'b1;
      pulse <= (left != CW'(1));
    end
  end
endmodule

// File: rtl/sofm_sync_edge.sv
// Two-flop synchronizer plus one history flop for rising-edge detection.
module sofm_sync_edge (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [2:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {sr[1:0], async_in};
  end

  assign rise = sr[1] & ~sr[2];
endmodule

// File: rtl/sofm_capture.sv
// Per-channel stamp register, delta, valid and sticky overrun.
module sofm_capture #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             hit,
  input  logic             ack,
  input  logic [CNT_W-1:0] stamp,
  output logic [CNT_W-1:0] delta,
  output logic             valid,
  output logic             ovr
);
  logic [CNT_W-1:0] prev;
  logic             primed;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev   <= '0;
      primed <= 1'b0;
      delta  <= '0;
      valid  <= 1'b0;
      ovr    <= 1'b0;
    end else if (!en) begin
      primed <= 1'b0;
      valid  <= 1'b0;
      ovr    <= 1'b0;
    end else if (hit) begin
      prev <= stamp;
      if (!primed) begin
        primed <= 1'b1;
      end else begin
        delta <= stamp - prev;
        valid <= 1'b1;
        if (valid && !ack) ovr <= 1'b1;
      end
    end else if (ack) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sof_audio_meter.sv
module sof_audio_meter #(
  parameter int unsigned NCH     = 2,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned STRETCH = 64
) (
  input  logic                 sys_clk,
  input  logic                 sys_rst,
  input  logic [NCH-1:0]       sof_stb,
  input  logic                 aud_clk,
  input  logic                 aud_rst,
  input  logic [NCH-1:0]       chan_en,
  input  logic [NCH-1:0]       rd_ack,
  output logic [NCH*CNT_W-1:0] tick_delta,
  output logic [NCH-1:0]       delta_valid,
  output logic [NCH-1:0]       delta_ovr
);
  logic [CNT_W-1:0] timebase;
  logic [NCH-1:0]   str_pulse;
  logic [NCH-1:0]   hit;

  always_ff @(posedge aud_clk) begin
    if (aud_rst) timebase <= '0;
    else         timebase <= timebase + 1'b1;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    sofm_stretch #(.WIDTH(STRETCH)) u_str (
      .clk   (sys_clk),
      .rst   (sys_rst),
      .stb   (sof_stb[i]),
      .pulse (str_pulse[i])
    );

    sofm_sync_edge u_sync (
      .clk      (aud_clk),
      .rst      (aud_rst),
      .async_in (str_pulse[i]),
      .rise     (hit[i])
    );

    sofm_capture #(.CNT_W(CNT_W)) u_cap (
      .clk   (aud_clk),
      .rst   (aud_rst),
      .en    (chan_en[i]),
      .hit   (hit[i]),
      .ack   (rd_ack[i]),
      .stamp (timebase),
      .delta (tick_delta[i*CNT_W +: CNT_W]),
      .valid (delta_valid[i]),
      .ovr   (delta_ovr[i])
    );
  end
endmodule

// File: rtl/sof_audio_meter_chk.sv
module sof_audio_meter_chk #(
  parameter int unsigned NCH     = 2,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned STRETCH = 64
) (
  input logic                 sys_clk,
  input logic                 sys_rst,
  input logic                 aud_clk,
  input logic                 aud_rst,
  input logic [NCH-1:0]       chan_en,
  input logic [NCH-1:0]       rd_ack,
  input logic [NCH*CNT_W-1:0] tick_delta,
  input logic [NCH-1:0]       delta_valid,
  input logic [NCH-1:0]       delta_ovr,
  input logic [NCH-1:0]       str_pulse
);
  for (genvar i = 0; i < NCH; i++) begin : g_chk
    int unsigned run;

    always_ff @(posedge sys_clk) begin
      if (sys_rst)           run <= 0;
      else if (str_pulse[i]) run <= run + 1;
      else                   run <= 0;
    end

    AST_STRETCH_WIDTH: assert property (@(posedge sys_clk) disable iff (sys_rst)
      $fell(str_pulse[i]) |-> (run == STRETCH)); // R2

    AST_DELTA_WITH_VALID: assert property (@(posedge aud_clk) disable iff (aud_rst)
      !$stable(tick_delta[i*CNT_W +: CNT_W]) |-> delta_valid[i]); // R6

    AST_VALID_CLEAR_CAUSE: assert property (@(posedge aud_clk) disable iff (aud_rst)
      $fell(delta_valid[i]) |-> ($past(rd_ack[i]) || !$past(chan_en[i]))); // R6

    AST_OVR_CAUSE: assert property (@(posedge aud_clk) disable iff (aud_rst)
      $rose(delta_ovr[i]) |-> $past(delta_valid[i])); // R7

    AST_OVR_STICKY: assert property (@(posedge aud_clk) disable iff (aud_rst)
      (delta_ovr[i] && chan_en[i]) |=> delta_ovr[i]); // R7

    AST_DISABLE_CLEARS: assert property (@(posedge aud_clk) disable iff (aud_rst)
      !chan_en[i] |=> (!delta_valid[i] && !delta_ovr[i])); // R8
  end
endmodule

bind sof_audio_meter sof_audio_meter_chk #(
  .NCH(NCH), .CNT_W(CNT_W), .STRETCH(STRETCH)
) u_chk (
  .sys_clk     (sys_clk),
  .sys_rst     (sys_rst),
  .aud_clk     (aud_clk),
  .aud_rst     (aud_rst),
  .chan_en     (chan_en),
  .rd_ack      (rd_ack),
  .tick_delta  (tick_delta),
  .delta_valid (delta_valid),
  .delta_ovr   (delta_ovr),
  .str_pulse   (str_pulse)
);

// File: tb/sof_audio_meter_test.sv
`timescale 1ns/1ps
module sof_audio_meter_test;
  localparam int unsigned NCH = 2;
  localparam int unsigned CW  = 12;
  localparam int unsigned STR = 16;

  logic sys_clk = 1'b0;
  logic aud_clk = 1'b0;
  logic sys_rst = 1'b1;
  logic aud_rst = 1'b1;
  logic [NCH-1:0] sof_stb = '0;
  logic [NCH-1:0] chan_en = '0;
  logic [NCH-1:0] rd_ack  = '0;
  logic [NCH*CW-1:0] tick_delta;
  logic [NCH-1:0] delta_valid, delta_ovr;

  always #4  sys_clk = ~sys_clk;   // 125 MHz
  always #10 aud_clk = ~aud_clk;   // 50 MHz audio clock

  sof_audio_meter #(.NCH(NCH), .CNT_W(CW), .STRETCH(STR)) uut (
    .sys_clk(sys_clk), .sys_rst(sys_rst), .sof_stb(sof_stb),
    .aud_clk(aud_clk), .aud_rst(aud_rst), .chan_en(chan_en),
    .rd_ack(rd_ack), .tick_delta(tick_delta),
    .delta_valid(delta_valid), .delta_ovr(delta_ovr)
  );

  int unsigned cyc = 0;
  int unsigned n_chk = 0;
  int unsigned n_fail = 0;
  bit done = 0;

  always @(posedge sys_clk) cyc <= cyc + 1;

  // Reference model per channel
  int unsigned last_t [NCH];
  bit          m_primed [NCH];
  bit          m_valid [NCH];
  bit          m_ovr [NCH];
  int unsigned m_delta [NCH];

  // 5 system cycles = 2 audio ticks at a fixed phase
  function automatic int unsigned exp_ticks(input int unsigned gap_cyc);
    return ((gap_cyc / 5) * 2) % (1 << CW);
  endfunction

  task automatic chk(input bit ok, input string req, input int unsigned act,
                     input int unsigned exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wait_cyc(input int unsigned t);
    while (cyc < t) @(negedge sys_clk);
  endtask

  task automatic fire(input int unsigned t, input logic [NCH-1:0] mask);
    wait_cyc(t);
    sof_stb = mask;
    @(negedge sys_clk);
    sof_stb = '0;
    for (int i = 0; i < NCH; i++) begin
      if (mask[i] && chan_en[i]) begin
        if (m_primed[i]) begin
          if (m_valid[i]) m_ovr[i] = 1;
          m_valid[i] = 1;
          m_delta[i] = exp_ticks(t - last_t[i]);
        end
        m_primed[i] = 1;
        last_t[i] = t;
      end
    end
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < NCH; i++) begin
      chk(delta_valid[i] == m_valid[i], req, delta_valid[i], m_valid[i]);
      chk(delta_ovr[i] == m_ovr[i], req, delta_ovr[i], m_ovr[i]);
      chk(tick_delta[i*CW +: CW] == m_delta[i], req,
          tick_delta[i*CW +: CW], m_delta[i]);
    end
  endtask

  task automatic ack(input logic [NCH-1:0] mask);
    rd_ack = mask;
    repeat (5) @(negedge sys_clk);
    rd_ack = '0;
    for (int i = 0; i < NCH; i++) if (mask[i]) m_valid[i] = 0;
  endtask

  task automatic set_en(input logic [NCH-1:0] v);
    chan_en = v;
    for (int i = 0; i < NCH; i++) if (!v[i]) begin
      m_primed[i] = 0; m_valid[i] = 0; m_ovr[i] = 0;
    end
    repeat (10) @(negedge sys_clk);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge sys_clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int unsigned t;
    int unsigned seed;
    seed = $urandom(32'd4711);
    for (int i = 0; i < NCH; i++) begin
      last_t[i] = 0; m_primed[i] = 0; m_valid[i] = 0; m_ovr[i] = 0; m_delta[i] = 0;
    end
    wait_cyc(12);
    sys_rst = 0;
    aud_rst = 0;
    wait_cyc(15);
    check_all("R1 reset state");
    set_en('1);

    // R4: first capture only records the stamp
    t = 100;
    fire(t, 2'b11);
    wait_cyc(t + 30);
    check_all("R4 first capture");

    // R5/R3: shared timebase, identical deltas; R6 ack clears valid
    t += 5 * 40;
    fire(t, 2'b11);
    wait_cyc(t + 30);
    check_all("R5 shared timebase delta");
    ack(2'b11);
    wait_cyc(t + 45);
    check_all("R6 ack clears valid");

    // R7: overrun without acknowledge
    t += 5 * 30;
    fire(t, 2'b01);
    wait_cyc(t + 30);
    check_all("R6 new delta sets valid");
    t += 5 * 25;
    fire(t, 2'b01);
    wait_cyc(t + 30);
    check_all("R7 overrun set");
    ack(2'b01);
    wait_cyc(t + 45);
    check_all("R7 overrun sticky after ack");

    // R2: retrigger inside the stretch is ignored
    t += 5 * 22;
    fire(t, 2'b01);
    wait_cyc(t + 3);
    sof_stb = 2'b01;
    @(negedge sys_clk);
    sof_stb = '0;
    wait_cyc(t + 30);
    check_all("R2 single capture per pulse");
    ack(2'b01);
    t += 5 * 33;
    fire(t, 2'b01);
    wait_cyc(t + 30);
    check_all("R2 retrigger did not restamp");
    ack(2'b01);

    // R8: disabled channel ignores strobes and clears flags
    wait_cyc(t + 60);
    set_en(2'b10);
    check_all("R8 disable clears flags");
    t += 5 * 30;
    fire(t, 2'b01);
    wait_cyc(t + 30);
    check_all("R8 strobe ignored while disabled");
    wait_cyc(t + 60);
    set_en(2'b11);
    t += 5 * 30;
    fire(t, 2'b01);
    wait_cyc(t + 30);
    check_all("R4 first capture after re-enable");
    t += 5 * 21;
    fire(t, 2'b01);
    wait_cyc(t + 30);
    check_all("R3 delta after re-enable");
    ack(2'b01);

    // R3: long gap just under the counter range, spans a wrap
    t += 5 * 2040;
    fire(t, 2'b01);
    wait_cyc(t + 30);
    check_all("R3 modular delta across wrap");
    ack(2'b01);

    // Random frame gaps, channel mixes and acknowledge patterns
    for (int n = 0; n < 40; n++) begin
      logic [NCH-1:0] mask;
      logic [NCH-1:0] am;
      mask = NCH'(1 + ($urandom % 3));
      am   = NCH'($urandom % 4);
      t += 5 * (20 + ($urandom % 400));
      fire(t, mask);
      wait_cyc(t + 30);
      check_all("R3 R7 random frame");
      ack(am);
      wait_cyc(t + 45);
      check_all("R6 random ack");
    end

    summary();
  end
endmodule